// File: doc/BRIEF.md
# Power Rail Housekeeping Sequencer

This block supervises one output rail of a redundant server supply. Every input is already a digital flag: a power-on request, an ac-good flag, the overvoltage, undervoltage, overtemperature and current-limit comparator flags, and a fault-clear pulse from the management bus. From these it drives four outputs: the power-enable for the converter, the output-good indication, a filtered ac-good indication and the crowbar drive. Each output has a polarity-select bit.

A prescaler derives microsecond and millisecond ticks from the system clock. Every filter and delay counts those ticks, so a bench can shorten them with parameters. A turn-on runs as follows. The request is filtered. Power-enable then rises and output-good follows after a selectable settling delay.

A commanded, overcurrent or overtemperature turn-off drops output-good first, as an early warning, and drops power-enable a selectable time later. Overvoltage always latches and cuts the rail at once with the crowbar asserted. Overcurrent that lasts long enough uses the same latch. Undervoltage is ignored while the rail ramps, while ac is low and while the output is in current limit. Undervoltage is also the only fault that may restart the rail by itself.

Top module: `psu_rail_sequencer`

## Requirements
- R1: After reset every output is at its logical inactive level: power-enable, output-good, ac-good and crowbar are all false.
- R2: The power-on request is filtered for 80, 0, 40 or 160 ms for a `cfg_pson_db_i` code of 00, 01, 10 or 11. Filters change state only on a tick of their timebase.
- R3: Power-enable rises only while the filtered request is true, the filtered ac-good is true and no latched fault is held. Output-good then rises 400, 200, 800 or 1600 ms later for a `cfg_on_dly_i` code of 00, 01, 10 or 11.
- R4: On a commanded, overcurrent or overtemperature turn-off, output-good falls first. Power-enable falls 2, 0, 1 or 4 ms later for a `cfg_off_dly_i` code of 00, 01, 10 or 11.
- R5: Overvoltage is filtered for OV_DB_US µs. It then drops power-enable and output-good in the next cycle and asserts the crowbar.
- R6: A latched fault stays in force after its cause is gone. It is released only by a false filtered power-on request, a fault-clear pulse or a reset. The rail then starts again if the request is true.
- R7: Current limit held continuously for (code+1) × OCP_UNIT_MS ms, with `cfg_ocp_time_i` giving the code, starts an early-warning turn-off. At the end of that turn-off the fault latch is set, the crowbar stays false and there is no automatic restart.
- R8: Undervoltage, filtered for UV_DB_US µs, has no effect during the turn-on delay, while the filtered ac-good is false, or while current limit is active.
- R9: An undervoltage trip in the output-good state drops power-enable and output-good together. With `cfg_auto_restart_i` set, power-enable rises again RETRY_MS ms later. With it clear, the rail stays off until released as in R6.
- R10: Overtemperature, filtered for OT_DB_US µs, starts an early-warning turn-off. The rail then stays off without a crowbar until released as in R6.
- R11: Each output port equals its logical value XOR its bit of `cfg_invert_i`. Bit 0 controls power-enable, bit 1 output-good, bit 2 ac-good and bit 3 crowbar.
- R12: The ac-good output follows the ac-good input after a filter of AC_DB_US µs.
- R13: Output-good is never true while power-enable is false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pson_req_i | input | 1 | Raw power-on request |
| ac_good_i | input | 1 | Raw ac-good flag |
| ov_flag_i | input | 1 | Output overvoltage comparator flag |
| uv_flag_i | input | 1 | Output undervoltage comparator flag |
| ot_flag_i | input | 1 | Overtemperature comparator flag |
| ilim_flag_i | input | 1 | Current-limit active flag |
| clr_fault_i | input | 1 | Fault-clear pulse from the bus |
| cfg_pson_db_i | input | 2 | Request filter code |
| cfg_on_dly_i | input | 2 | Output-good settling delay code |
| cfg_off_dly_i | input | 2 | Early-warning lead code |
| cfg_ocp_time_i | input | 2 | Overcurrent ride-through code |
| cfg_auto_restart_i | input | 1 | Undervoltage auto-restart enable |
| cfg_invert_i | input | 4 | Output polarity bits |
| pwr_en_o | output | 1 | Power-enable |
| dc_good_o | output | 1 | Output-good |
| ac_good_o | output | 1 | Filtered ac-good |
| crowbar_o | output | 1 | Crowbar drive |

## Verification
The sequencing path is driven with random codes for the request filter, settling delay, warning lead and polarity, under a fixed seed. Each edge is timed against a window computed from the code, which separates the four decodes of each field and shows whether output-good leads power-enable on the way down. Directed cases put each fault in turn on a running rail. Overvoltage against overcurrent shows whether the crowbar is tied to the cause. Undervoltage raised during ramp, low ac and current limit separates blanked from live. Undervoltage with and without auto-restart, against overtemperature, shows which faults retry and which hold until a clear or a request cycle.

// File: rtl/hk_pkg.sv
`timescale 1ns/1ps
package hk_pkg;

   typedef enum logic [2:0] {
      HK_IDLE,
      HK_RAMP,
      HK_GOOD,
      HK_WARN,
      HK_RETRY,
      HK_HOLD
   } hk_state_t;

   typedef enum logic [1:0] {
      WHY_CMD,
      WHY_OCP,
      WHY_OT
   } hk_why_t;

   localparam int OUT_N       = 4;
   localparam int OUT_PEN     = 0;
   localparam int OUT_DCOK    = 1;
   localparam int OUT_ACOK    = 2;
   localparam int OUT_CROWBAR = 3;

   localparam int PSON_DB_MAX_MS = 160;
   localparam int ON_DLY_MAX_MS  = 1600;

   function automatic int unsigned pson_db_ms(input logic [1:0] code);
      case (code)
         2'b00:   return 80;
         2'b01:   return 0;
         2'b10:   return 40;
         default: return 160;
      endcase
   endfunction

   function automatic int unsigned on_dly_ms(input logic [1:0] code);
      case (code)
         2'b00:   return 400;
         2'b01:   return 200;
         2'b10:   return 800;
         default: return 1600;
      endcase
   endfunction

   function automatic int unsigned off_dly_ms(input logic [1:0] code);
      case (code)
         2'b00:   return 2;
         2'b01:   return 0;
         2'b10:   return 1;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/hk_timebase.sv
`timescale 1ns/1ps
module hk_timebase #(
   parameter int CLK_PER_US = 200,
   parameter int US_PER_MS  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic us_tick,
   output logic ms_tick
);
   localparam int CW = $clog2(CLK_PER_US + 1);
   localparam int MW = $clog2(US_PER_MS + 1);
   localparam logic [CW-1:0] C_LAST = CW'(CLK_PER_US - 1);
   localparam logic [MW-1:0] M_LAST = MW'(US_PER_MS - 1);

   logic [CW-1:0] ccnt;
   logic [MW-1:0] mcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccnt    <= '0;
         us_tick <= 1'b0;
      end else if (ccnt == C_LAST) begin
         ccnt    <= '0;
         us_tick <= 1'b1;
      end else begin
         ccnt    <= ccnt + 1'b1;
         us_tick <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt <= '0;
      end else if (us_tick) begin
         if (mcnt == M_LAST) mcnt <= '0;
         else                mcnt <= mcnt + 1'b1;
      end
   end

   assign ms_tick = us_tick && (mcnt == M_LAST);

   generate
      if (CLK_PER_US > 1) begin : g_gap_chk
         p_us_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            us_tick |=> !us_tick);
      end
   endgenerate

endmodule

// File: rtl/hk_debounce.sv
`timescale 1ns/1ps
module hk_debounce #(
   parameter int   CW   = 8,
   parameter int   SYNC = 2,
   parameter logic INIT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] len,
   input  logic          raw,
   output logic          q
);
   logic          s;
   logic [CW-1:0] cnt;

   generate
      if (SYNC > 0) begin : g_sync
         logic [SYNC-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= {SYNC{INIT}};
            end else begin
               sh[0] <= raw;
               for (int i = 1; i < SYNC; i++) sh[i] <= sh[i-1];
            end
         end
         assign s = sh[SYNC-1];
      end else begin : g_direct
         assign s = raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= INIT;
         cnt <= '0;
      end else if (s == q) begin
         cnt <= '0;
      end else if (len == '0) begin
         q   <= s;
         cnt <= '0;
      end else if (tick) begin
         if (({1'b0, cnt} + 1'b1) >= {1'b0, len}) begin
            q   <= s;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && len != '0) |=> $stable(q));

endmodule

// File: rtl/hk_seq_core.sv
`timescale 1ns/1ps
module hk_seq_core
   import hk_pkg::*;
#(
   parameter int OCP_UNIT_MS = 1000,
   parameter int RETRY_MS    = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic       pson_ok,
   input  logic       ac_ok,
   input  logic       ov,
   input  logic       uv,
   input  logic       ot,
   input  logic       ilim,
   input  logic       clr,
   input  logic [1:0] cfg_on_dly,
   input  logic [1:0] cfg_off_dly,
   input  logic [1:0] cfg_ocp_time,
   input  logic       cfg_auto,
   output logic       pen,
   output logic       dcok,
   output logic       crowbar
);
   localparam int TMR_MAX = (RETRY_MS > ON_DLY_MAX_MS) ? RETRY_MS : ON_DLY_MAX_MS;
   localparam int TW      = $clog2(TMR_MAX + 1);
   localparam int OCP_MAX = 4 * OCP_UNIT_MS;
   localparam int OW      = $clog2(OCP_MAX + 1);

   hk_state_t     st, st_n;
   hk_why_t       why, why_n;
   logic [TW-1:0] tmr;
   logic [OW-1:0] ocp_cnt;
   logic          latch, ov_hit;
   logic          ocp_trip, uv_trip, release_req;
   int unsigned   ocp_target;

   assign ocp_target  = (32'(cfg_ocp_time) + 1) * OCP_UNIT_MS;
   assign ocp_trip    = (st == HK_GOOD) && ilim && (32'(ocp_cnt) >= ocp_target);
   assign uv_trip     = (st == HK_GOOD) && uv && ac_ok && !ilim;
   assign release_req = clr || !pson_ok;

   always_comb begin
      st_n  = st;
      why_n = why;
      unique case (st)
         HK_IDLE:
            if (pson_ok && ac_ok && !latch) st_n = HK_RAMP;
         HK_RAMP:
            if (!pson_ok) begin
               st_n = HK_WARN; why_n = WHY_CMD;
            end else if (ot) begin
               st_n = HK_WARN; why_n = WHY_OT;
            end else if (32'(tmr) >= on_dly_ms(cfg_on_dly)) begin
               st_n = HK_GOOD;
            end
         HK_GOOD:
            if (!pson_ok) begin
               st_n = HK_WARN; why_n = WHY_CMD;
            end else if (ot) begin
               st_n = HK_WARN; why_n = WHY_OT;
            end else if (ocp_trip) begin
               st_n = HK_WARN; why_n = WHY_OCP;
            end else if (uv_trip) begin
               st_n = cfg_auto ? HK_RETRY : HK_HOLD;
            end
         HK_WARN:
            if (32'(tmr) >= off_dly_ms(cfg_off_dly))
               st_n = (why == WHY_CMD) ? HK_IDLE : HK_HOLD;
         HK_RETRY:
            if (!pson_ok || 32'(tmr) >= 32'(RETRY_MS)) st_n = HK_IDLE;
         HK_HOLD:
            if (release_req) st_n = HK_IDLE;
         default:
            st_n = HK_IDLE;
      endcase
      if (ov) st_n = HK_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= HK_IDLE;
         why <= WHY_CMD;
         tmr <= '0;
      end else begin
         st  <= st_n;
         why <= why_n;
         if (st_n != st)                 tmr <= '0;
         else if (ms_tick && tmr != '1)  tmr <= tmr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ocp_cnt <= '0;
      end else if (st == HK_GOOD && ilim) begin
         if (ms_tick && ocp_cnt != '1) ocp_cnt <= ocp_cnt + 1'b1;
      end else begin
         ocp_cnt <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch  <= 1'b0;
         ov_hit <= 1'b0;
      end else if (ov) begin
         latch  <= 1'b1;
         ov_hit <= 1'b1;
      end else if (st == HK_WARN && st_n == HK_HOLD && why == WHY_OCP) begin
         latch  <= 1'b1;
      end else if (release_req) begin
         latch  <= 1'b0;
         ov_hit <= 1'b0;
      end
   end

   assign pen     = (st == HK_RAMP) || (st == HK_GOOD) || (st == HK_WARN);
   assign dcok    = (st == HK_GOOD);
   assign crowbar = ov_hit;

   p_dcok_pen_r13: assert property (@(posedge clk) disable iff (!rst_n)
      dcok |-> pen);

   p_latch_pen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> !pen);

   p_ov_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ov |=> (!pen && !dcok && crowbar));

   p_crowbar_in_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      crowbar |-> latch);

   p_start_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pen) |-> ($past(pson_ok) && $past(ac_ok) && !$past(latch)));

endmodule

// File: rtl/psu_rail_sequencer.sv
`timescale 1ns/1ps
module psu_rail_sequencer
   import hk_pkg::*;
#(
   parameter int CLK_PER_US  = 200,
   parameter int US_PER_MS   = 1000,
   parameter int OV_DB_US    = 16,
   parameter int UV_DB_US    = 450,
   parameter int OT_DB_US    = 450,
   parameter int AC_DB_US    = 1000,
   parameter int OCP_UNIT_MS = 1000,
   parameter int RETRY_MS    = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pson_req_i,
   input  logic       ac_good_i,
   input  logic       ov_flag_i,
   input  logic       uv_flag_i,
   input  logic       ot_flag_i,
   input  logic       ilim_flag_i,
   input  logic       clr_fault_i,
   input  logic [1:0] cfg_pson_db_i,
   input  logic [1:0] cfg_on_dly_i,
   input  logic [1:0] cfg_off_dly_i,
   input  logic [1:0] cfg_ocp_time_i,
   input  logic       cfg_auto_restart_i,
   input  logic [3:0] cfg_invert_i,
   output logic       pwr_en_o,
   output logic       dc_good_o,
   output logic       ac_good_o,
   output logic       crowbar_o
);
   localparam int PS_W = $clog2(PSON_DB_MAX_MS + 1);
   localparam int OV_W = $clog2(OV_DB_US + 1);
   localparam int UV_W = $clog2(UV_DB_US + 1);
   localparam int OT_W = $clog2(OT_DB_US + 1);
   localparam int AC_W = $clog2(AC_DB_US + 1);

   generate
      if (CLK_PER_US < 1)  begin : g_bad_clk   $error("CLK_PER_US must be at least 1"); end
      if (US_PER_MS < 1)   begin : g_bad_ms    $error("US_PER_MS must be at least 1"); end
      if (OCP_UNIT_MS < 1) begin : g_bad_ocp   $error("OCP_UNIT_MS must be at least 1"); end
      if (RETRY_MS < 1)    begin : g_bad_retry $error("RETRY_MS must be at least 1"); end
      if (SYNC_STAGES < 0) begin : g_bad_sync  $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic us_tick, ms_tick;
   logic pson_db, ac_db, ov_db, uv_db, ot_db, ilim_s, clr_s;
   logic pen, dcok, crowbar;

   hk_timebase #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tb (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick));

   hk_debounce #(.CW(PS_W), .SYNC(SYNC_STAGES)) u_db_pson (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick),
      .len(PS_W'(pson_db_ms(cfg_pson_db_i))), .raw(pson_req_i), .q(pson_db));

   hk_debounce #(.CW(AC_W), .SYNC(SYNC_STAGES)) u_db_ac (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .len(AC_W'(AC_DB_US)), .raw(ac_good_i), .q(ac_db));

   hk_debounce #(.CW(OV_W), .SYNC(SYNC_STAGES)) u_db_ov (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .len(OV_W'(OV_DB_US)), .raw(ov_flag_i), .q(ov_db));

   hk_debounce #(.CW(UV_W), .SYNC(SYNC_STAGES)) u_db_uv (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .len(UV_W'(UV_DB_US)), .raw(uv_flag_i), .q(uv_db));

   hk_debounce #(.CW(OT_W), .SYNC(SYNC_STAGES)) u_db_ot (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .len(OT_W'(OT_DB_US)), .raw(ot_flag_i), .q(ot_db));

   hk_debounce #(.CW(1), .SYNC(SYNC_STAGES)) u_sy_ilim (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .len(1'b0), .raw(ilim_flag_i), .q(ilim_s));

   hk_debounce #(.CW(1), .SYNC(SYNC_STAGES)) u_sy_clr (
      .clk(clk), .rst_n(rst_n), .tick(us_tick),
      .len(1'b0), .raw(clr_fault_i), .q(clr_s));

   hk_seq_core #(.OCP_UNIT_MS(OCP_UNIT_MS), .RETRY_MS(RETRY_MS)) u_core (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .pson_ok(pson_db), .ac_ok(ac_db), .ov(ov_db), .uv(uv_db), .ot(ot_db),
      .ilim(ilim_s), .clr(clr_s),
      .cfg_on_dly(cfg_on_dly_i), .cfg_off_dly(cfg_off_dly_i),
      .cfg_ocp_time(cfg_ocp_time_i), .cfg_auto(cfg_auto_restart_i),
      .pen(pen), .dcok(dcok), .crowbar(crowbar));

   logic [OUT_N-1:0] logic_bus, pin_bus;

   always_comb begin
      logic_bus              = '0;
      logic_bus[OUT_PEN]     = pen;
      logic_bus[OUT_DCOK]    = dcok;
      logic_bus[OUT_ACOK]    = ac_db;
      logic_bus[OUT_CROWBAR] = crowbar;
   end

   generate
      for (genvar g = 0; g < OUT_N; g++) begin : g_pol
         assign pin_bus[g] = logic_bus[g] ^ cfg_invert_i[g];
      end
   endgenerate

   assign pwr_en_o  = pin_bus[OUT_PEN];
   assign dc_good_o = pin_bus[OUT_DCOK];
   assign ac_good_o = pin_bus[OUT_ACOK];
   assign crowbar_o = pin_bus[OUT_CROWBAR];

endmodule

// File: tb/tb_psu_rail_sequencer.sv
`timescale 1ns/1ps
module tb_psu_rail_sequencer;
   localparam int CPU = 2, UPM = 4, MSC = CPU * UPM;
   localparam int OV_US = 16, UV_US = 20, OT_US = 20, AC_US = 8;
   localparam int OCP_MS = 50, RETRY = 60, TOL = 12;
   localparam int I_PEN = 0, I_DC = 1, I_AC = 2, I_CB = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, pson, ac, ov, uv, ot, ilim, clr, autor;
   logic [1:0] c_ps, c_on, c_off, c_ocp;
   logic [3:0] inv;
   logic pwr_en_o, dc_good_o, ac_good_o, crowbar_o;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   psu_rail_sequencer #(
      .CLK_PER_US(CPU), .US_PER_MS(UPM), .OV_DB_US(OV_US), .UV_DB_US(UV_US),
      .OT_DB_US(OT_US), .AC_DB_US(AC_US), .OCP_UNIT_MS(OCP_MS), .RETRY_MS(RETRY)
   ) dut (
      .clk(clk), .rst_n(rst_n), .pson_req_i(pson), .ac_good_i(ac), .ov_flag_i(ov),
      .uv_flag_i(uv), .ot_flag_i(ot), .ilim_flag_i(ilim), .clr_fault_i(clr),
      .cfg_pson_db_i(c_ps), .cfg_on_dly_i(c_on), .cfg_off_dly_i(c_off),
      .cfg_ocp_time_i(c_ocp), .cfg_auto_restart_i(autor), .cfg_invert_i(inv),
      .pwr_en_o(pwr_en_o), .dc_good_o(dc_good_o), .ac_good_o(ac_good_o),
      .crowbar_o(crowbar_o));

   function automatic int ps_ms(input logic [1:0] c);
      case (c) 2'b00: return 80; 2'b01: return 0; 2'b10: return 40; default: return 160; endcase
   endfunction
   function automatic int on_ms(input logic [1:0] c);
      case (c) 2'b00: return 400; 2'b01: return 200; 2'b10: return 800; default: return 1600; endcase
   endfunction
   function automatic int off_ms(input logic [1:0] c);
      case (c) 2'b00: return 2; 2'b01: return 0; 2'b10: return 1; default: return 4; endcase
   endfunction
   function automatic logic pin(input int i);
      case (i) I_PEN: return pwr_en_o; I_DC: return dc_good_o; I_AC: return ac_good_o; default: return crowbar_o; endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   task automatic wait_lvl(input int i, input logic v, input int lim, output int n);
      n = 0;
      while (pin(i) !== (v ^ inv[i]) && n <= lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   // edge must appear within exp +/- TOL cycles
   task automatic win(input string req, input int i, input logic v, input int exp);
      int n, lo;
      lo = (exp > TOL) ? exp - TOL : 0;
      wait_lvl(i, v, exp + TOL + 8, n);
      chk(n >= lo && n <= exp + TOL, req, n, exp);
   endtask

   task automatic reach(input string req, input int i, input logic v, input int lim);
      int n;
      wait_lvl(i, v, lim, n);
      chk(n <= lim, req, n, lim);
   endtask

   task automatic lvl(input string req, input int i, input logic v);
      chk(pin(i) === (v ^ inv[i]), req, int'(pin(i)), int'(v ^ inv[i]));
   endtask

   task automatic pulse_clr();
      clr = 1'b1; @(negedge clk); clr = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=190000 expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [1:0] rp, ron, roff;
      void'($urandom(32'd7151));
      rst_n = 0; pson = 0; ac = 0; ov = 0; uv = 0; ot = 0; ilim = 0; clr = 0; autor = 0;
      c_ps = 2'b01; c_on = 2'b01; c_off = 2'b00; c_ocp = 2'b00; inv = 4'b0000;
      idle(5); rst_n = 1; idle(2);

      // R1 reset state
      lvl("R1", I_PEN, 0); lvl("R1", I_DC, 0); lvl("R1", I_AC, 0); lvl("R1", I_CB, 0);

      // R3 no start without ac-good; R12 ac filter
      pson = 1; idle(100); lvl("R3", I_PEN, 0);
      ac = 1; win("R12", I_AC, 1, AC_US * CPU);
      win("R3", I_PEN, 1, 0);
      win("R3", I_DC, 1, on_ms(c_on) * MSC);

      // R5 overvoltage cuts at once and crowbars; R6 latch and clear
      ov = 1; win("R5", I_CB, 1, OV_US * CPU);
      lvl("R5", I_PEN, 0); lvl("R5", I_DC, 0);
      ov = 0; idle(300);
      lvl("R6", I_CB, 1); lvl("R6", I_PEN, 0);
      pulse_clr();
      win("R6", I_CB, 0, 0); win("R6", I_PEN, 1, 0);
      reach("R3", I_DC, 1, 1700);

      // R7 overcurrent ride-through, shared latch, no crowbar, no retry
      autor = 1; ilim = 1;
      win("R7", I_DC, 0, OCP_MS * MSC);
      win("R4", I_PEN, 0, off_ms(c_off) * MSC);
      lvl("R7", I_CB, 0);
      ilim = 0; idle(600); lvl("R7", I_PEN, 0);
      autor = 0; pson = 0; idle(20); pson = 1;
      win("R6", I_PEN, 1, 0);

      // R8 undervoltage blanked during turn-on delay
      uv = 1; idle(100); lvl("R8", I_PEN, 1);
      uv = 0; reach("R3", I_DC, 1, 1700);

      // R8 blanked during current limit
      ilim = 1; uv = 1; idle(100);
      lvl("R8", I_PEN, 1); lvl("R8", I_DC, 1);
      uv = 0; idle(60); ilim = 0; idle(10);

      // R8 blanked while ac low; R12 ac falling
      ac = 0; win("R12", I_AC, 0, AC_US * CPU);
      uv = 1; idle(100); lvl("R8", I_PEN, 1);
      uv = 0; idle(60); ac = 1; idle(40);

      // R9 undervoltage with auto-restart
      autor = 1; uv = 1;
      win("R9", I_PEN, 0, UV_US * CPU);
      lvl("R13", I_DC, 0);
      uv = 0; win("R9", I_PEN, 1, RETRY * MSC);
      reach("R3", I_DC, 1, 1700);

      // R9 undervoltage without auto-restart
      autor = 0; uv = 1;
      win("R9", I_PEN, 0, UV_US * CPU);
      uv = 0; idle(700); lvl("R9", I_PEN, 0);
      pson = 0; idle(20); pson = 1;
      reach("R6", I_PEN, 1, 20); reach("R3", I_DC, 1, 1700);

      // R10 overtemperature with early warning, held off
      ot = 1; win("R10", I_DC, 0, OT_US * CPU);
      win("R4", I_PEN, 0, off_ms(c_off) * MSC);
      ot = 0; idle(200); lvl("R10", I_PEN, 0); lvl("R10", I_CB, 0);
      pulse_clr(); reach("R6", I_PEN, 1, 20); reach("R3", I_DC, 1, 1700);

      // R11 polarity applied at the pins only
      inv = 4'b1111; @(negedge clk);
      chk(pwr_en_o === 1'b0, "R11", int'(pwr_en_o), 0);
      chk(dc_good_o === 1'b0, "R11", int'(dc_good_o), 0);
      chk(ac_good_o === 1'b0, "R11", int'(ac_good_o), 0);
      chk(crowbar_o === 1'b1, "R11", int'(crowbar_o), 1);

      // R2 R3 R4 random codes and polarity
      for (int it = 0; it < 5; it++) begin
         rp = 2'($urandom % 4); ron = 2'($urandom % 4); roff = 2'($urandom % 4);
         inv = 4'($urandom % 16);
         c_ps = rp; c_off = roff; idle(4);
         pson = 0;
         win("R2", I_DC, 0, ps_ms(rp) * MSC);
         win("R4", I_PEN, 0, off_ms(roff) * MSC);
         lvl("R1", I_CB, 0);
         idle(20); c_on = ron;
         pson = 1;
         win("R2", I_PEN, 1, ps_ms(rp) * MSC);
         win("R3", I_DC, 1, on_ms(ron) * MSC);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule